// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. It takes the four standard test-port inputs plus an active-low asynchronous reset. A sixteen-state controller steps on every rising edge of the test clock, as directed by the mode-select input. A 7-bit instruction register decides which data register is placed between the serial input and the serial output.

Three data registers are provided:
- a 32-bit identification register, whose value comes from a two-bit speed-grade strap;
- a one-bit bypass stage;
- a generic user register with a serial shift stage and a parallel shadow stage.

Any instruction code that is not decoded, including the reserved ones, falls back to the bypass stage. Two instructions also drive pin-control outputs while bypass is selected. One holds the chip's outputs at clamped values taken from the external boundary chain. The other floats every output and bidirectional pin.

The serial output changes only on the falling clock edge and is enabled only while a register is being shifted. The block has no streaming data path, so no valid/ready handshake applies: every pin is a plain level or clock-qualified control. Back-pressure does not exist here, because the test clock alone paces all transfers.

Top module: `tap_port_ctrl`

## Requirements
- R1: The controller follows the standard sixteen-state transition graph on the rising edge of `tck`. Holding `tms` high for five consecutive rising edges reaches Test-Logic-Reset from any state, and Test-Logic-Reset stays put while `tms` is high.
- R2: Driving `trst_n` low forces Test-Logic-Reset at once, without a clock. Whenever the controller is in Test-Logic-Reset, the active instruction is the identification code 7'b1111110, `pin_clamp` and `pin_hiz` are low, and `tdo_en` is low.
- R3: The instruction register is 7 bits wide and is shifted least significant bit first. Capture-IR loads 7'b0000001, so the first two bits out are 1 then 0. A shifted-in code becomes active only at Update-IR; until then the previous instruction's outputs persist.
- R4: Code 7'b1111110 places the 32-bit identification register on the scan path, shifted least significant bit first.
- R5: The identification value is 32'h09274013 when `grade_sel` is 2'b00 or 2'b11, 32'h09275013 when it is 2'b01, and 32'h09277013 when it is 2'b10. The strap is sampled in Capture-DR.
- R6: Every code other than 7'b1111110 and the user-register code selects a one-bit bypass stage that captures 0. A scan of N bits therefore returns a 0 followed by the first N-1 input bits. This covers the reserved codes 7'b0000011 and 7'b1000000 through 7'b1000110.
- R7: Code 7'b1001001 raises `pin_clamp` and selects bypass; `pin_hiz` stays low.
- R8: Code 7'b1001010 raises `pin_hiz` and selects bypass; `pin_clamp` stays low.
- R9: Code `USR_OP` (default 7'b0100000) selects the generic register of `USR_W` bits. In Capture-DR the shadow is copied into the shift stage. In Update-DR the shift stage is copied into the shadow, which drives `udr_q`. `udr_q` changes at no other time.
- R10: `tdo` changes only on the falling edge of `tck`. `tdo_en` is high exactly in the half-cycles that follow a falling edge taken in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| grade_sel | input | 2 | Speed-grade strap choosing the identification value |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo` |
| pin_clamp | output | 1 | Hold chip outputs at boundary-chain values |
| pin_hiz | output | 1 | Float all chip output and bidirectional pins |
| udr_q | output | USR_W | Parallel shadow of the generic user register |

## Verification
On every clock, the assertions check four things:
- Test-Logic-Reset is held under `tms` high, and while in it the identification instruction is active with both pin controls low.
- The active instruction changes only on Update-IR or on entry to Test-Logic-Reset.
- `tdo_en` tracks the shift states.
- The user shadow moves only after Update-DR.

The bench scenarios show what a property cannot easily express. These are the bit order and contents of each scan path, the one-bit delay through bypass for every reserved and unlisted code, and the identification value under each strap. They also cover the five-clock escape from the middle of a shift, the asynchronous reset dropping the pin controls, and `tdo` holding steady across the rising edge.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W = 7;

  localparam logic [IR_W-1:0] OP_IDCODE = 7'b1111110;
  localparam logic [IR_W-1:0] OP_CLAMP  = 7'b1001001;
  localparam logic [IR_W-1:0] OP_HIZ    = 7'b1001010;
  localparam logic [IR_W-1:0] IR_CAPTURE = 7'b0000001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  typedef enum logic [1:0] {
    DSEL_BYP = 2'd0,
    DSEL_ID  = 2'd1,
    DSEL_USR = 2'd2
  } dsel_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tms,
  output tap_st_e st,
  output tap_st_e st_nx
);
  always_comb begin
    st_nx = st;
    unique case (st)
      ST_TLR:    st_nx = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    st_nx = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: st_nx = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: st_nx = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  st_nx = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: st_nx = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: st_nx = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: st_nx = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: st_nx = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: st_nx = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: st_nx = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  st_nx = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: st_nx = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: st_nx = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: st_nx = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: st_nx = tms ? ST_SEL_DR : ST_RTI;
      default:   st_nx = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st <= ST_TLR;
    else         st <= st_nx;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter logic [IR_W-1:0] USR_OP = 7'b0100000
) (
  input  logic            tck,
  input  logic            trst_n,
  input  tap_st_e         st,
  input  tap_st_e         st_nx,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_tdo,
  output dsel_e           dsel,
  output logic            pin_clamp,
  output logic            pin_hiz
);
  logic [IR_W-1:0] ir_sh;

  // serial stage: capture fixed pattern, shift toward bit 0
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= '0;
    end else if (st == ST_CAP_IR) begin
      ir_sh <= IR_CAPTURE;
    end else if (st == ST_SH_IR) begin
      ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end
  end

  // active instruction: reset on entry to TLR, load at Update-IR
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_q <= OP_IDCODE;
    end else if (st_nx == ST_TLR) begin
      ir_q <= OP_IDCODE;
    end else if (st == ST_UPD_IR) begin
      ir_q <= ir_sh;
    end
  end

  assign ir_tdo = ir_sh[0];

  always_comb begin
    if (ir_q == OP_IDCODE)  dsel = DSEL_ID;
    else if (ir_q == USR_OP) dsel = DSEL_USR;
    else                     dsel = DSEL_BYP;
  end

  assign pin_clamp = (ir_q == OP_CLAMP);
  assign pin_hiz   = (ir_q == OP_HIZ);
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int          ID_W   = 32,
  parameter int          USR_W  = 8,
  parameter logic [31:0] ID_G0  = 32'h09274013,
  parameter logic [31:0] ID_G1  = 32'h09275013,
  parameter logic [31:0] ID_G2  = 32'h09277013
) (
  input  logic             tck,
  input  logic             trst_n,
  input  tap_st_e          st,
  input  dsel_e            dsel,
  input  logic             tdi,
  input  logic [1:0]       grade_sel,
  output logic             dr_tdo,
  output logic [USR_W-1:0] udr_q
);
  localparam int NGRADE = 3;

  logic [31:0] grade_tab [NGRADE];
  assign grade_tab[0] = ID_G0;
  assign grade_tab[1] = ID_G1;
  assign grade_tab[2] = ID_G2;

  logic [ID_W-1:0] id_val;
  always_comb begin
    if (grade_sel == 2'b01)      id_val = grade_tab[1][ID_W-1:0];
    else if (grade_sel == 2'b10) id_val = grade_tab[2][ID_W-1:0];
    else                         id_val = grade_tab[0][ID_W-1:0];
  end

  logic cap, shf, upd;
  assign cap = (st == ST_CAP_DR);
  assign shf = (st == ST_SH_DR);
  assign upd = (st == ST_UPD_DR);

  // bypass stage
  logic byp_q;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                          byp_q <= 1'b0;
    else if (dsel == DSEL_BYP && cap)     byp_q <= 1'b0;
    else if (dsel == DSEL_BYP && shf)     byp_q <= tdi;
  end

  // identification stage
  logic [ID_W-1:0] id_sh;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                          id_sh <= '0;
    else if (dsel == DSEL_ID && cap)      id_sh <= id_val;
    else if (dsel == DSEL_ID && shf)      id_sh <= {tdi, id_sh[ID_W-1:1]};
  end

  // generic register: shift stage plus parallel shadow
  logic [USR_W-1:0] usr_sh;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                          usr_sh <= '0;
    else if (dsel == DSEL_USR && cap)     usr_sh <= udr_q;
    else if (dsel == DSEL_USR && shf)     usr_sh <= {tdi, usr_sh[USR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                          udr_q <= '0;
    else if (dsel == DSEL_USR && upd)     udr_q <= usr_sh;
  end

  always_comb begin
    unique case (dsel)
      DSEL_ID:  dr_tdo = id_sh[0];
      DSEL_USR: dr_tdo = usr_sh[0];
      default:  dr_tdo = byp_q;
    endcase
  end
endmodule

// File: rtl/tap_port_ctrl.sv
module tap_port_ctrl
  import tap_pkg::*;
#(
  parameter int                ID_W   = 32,
  parameter int                USR_W  = 8,
  parameter logic [IR_W-1:0]   USR_OP = 7'b0100000,
  parameter logic [31:0]       ID_G0  = 32'h09274013,
  parameter logic [31:0]       ID_G1  = 32'h09275013,
  parameter logic [31:0]       ID_G2  = 32'h09277013
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [1:0]       grade_sel,
  output logic             tdo,
  output logic             tdo_en,
  output logic             pin_clamp,
  output logic             pin_hiz,
  output logic [USR_W-1:0] udr_q
);
  tap_st_e         st, st_nx;
  logic [IR_W-1:0] ir_q;
  logic            ir_tdo, dr_tdo;
  dsel_e           dsel;

  tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .st(st), .st_nx(st_nx)
  );

  tap_ir #(.USR_OP(USR_OP)) u_ir (
    .tck(tck), .trst_n(trst_n), .st(st), .st_nx(st_nx), .tdi(tdi),
    .ir_q(ir_q), .ir_tdo(ir_tdo), .dsel(dsel),
    .pin_clamp(pin_clamp), .pin_hiz(pin_hiz)
  );

  tap_dr #(
    .ID_W(ID_W), .USR_W(USR_W), .ID_G0(ID_G0), .ID_G1(ID_G1), .ID_G2(ID_G2)
  ) u_dr (
    .tck(tck), .trst_n(trst_n), .st(st), .dsel(dsel), .tdi(tdi),
    .grade_sel(grade_sel), .dr_tdo(dr_tdo), .udr_q(udr_q)
  );

  // output stage retimed to the falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= (st == ST_SH_IR) ? ir_tdo : dr_tdo;
      tdo_en <= (st == ST_SH_IR) || (st == ST_SH_DR);
    end
  end
endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
  import tap_pkg::*;
#(
  parameter int USR_W = 8
) (
  input logic             tck,
  input logic             trst_n,
  input logic             tms,
  input tap_st_e          st,
  input logic [IR_W-1:0]  ir_q,
  input logic             tdo_en,
  input logic             pin_clamp,
  input logic             pin_hiz,
  input logic [USR_W-1:0] udr_q
);
  AST_TLR_STICKY: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_TLR && tms) |=> (st == ST_TLR)); // R1

  AST_TLR_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_TLR) |-> (ir_q == OP_IDCODE && !pin_clamp && !pin_hiz)); // R2

  AST_IR_UPDATE_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_q != $past(ir_q)) |-> ($past(st) == ST_UPD_IR || st == ST_TLR)); // R3

  AST_PINS_EXCLUSIVE: assert property (@(posedge tck) disable iff (!trst_n)
    !(pin_clamp && pin_hiz)); // R7

  AST_USR_UPDATE_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
    (udr_q != $past(udr_q)) |-> ($past(st) == ST_UPD_DR)); // R9

  AST_TDOEN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en == (st == ST_SH_DR || st == ST_SH_IR)); // R10
endmodule

bind tap_port_ctrl tap_port_chk #(.USR_W(USR_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .st(st), .ir_q(ir_q),
  .tdo_en(tdo_en), .pin_clamp(pin_clamp), .pin_hiz(pin_hiz), .udr_q(udr_q)
);

// File: tb/sim_tap_port_ctrl.sv
module sim_tap_port_ctrl;
  localparam int USR_W = 8;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [1:0] grade_sel = 2'b00;
  logic tdo, tdo_en, pin_clamp, pin_hiz;
  logic [USR_W-1:0] udr_q;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5 tck = ~tck;

  tap_port_ctrl u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .grade_sel(grade_sel),
    .tdo(tdo), .tdo_en(tdo_en), .pin_clamp(pin_clamp), .pin_hiz(pin_hiz),
    .udr_q(udr_q)
  );

  // {opcode[6:0], kind[1:0] (0 bypass, 1 id, 2 user), clamp, hiz}
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    {7'b1111110, 2'd1, 1'b0, 1'b0},
    {7'b0000011, 2'd0, 1'b0, 1'b0},
    {7'b1001001, 2'd0, 1'b1, 1'b0},
    {7'b1000000, 2'd0, 1'b0, 1'b0},
    {7'b1001010, 2'd0, 1'b0, 1'b1},
    {7'b1000011, 2'd0, 1'b0, 1'b0},
    {7'b0100000, 2'd2, 1'b0, 1'b0},
    {7'b1000110, 2'd0, 1'b0, 1'b0},
    {7'b0100000, 2'd2, 1'b0, 1'b0},
    {7'b0000000, 2'd0, 1'b0, 1'b0},
    {7'b1111111, 2'd0, 1'b0, 1'b0},
    {7'b0001001, 2'd0, 1'b0, 1'b0}
  };

  function automatic logic [31:0] exp_id(input logic [1:0] g);
    case (g)
      2'b01:   return 32'h09275013;
      2'b10:   return 32'h09277013;
      default: return 32'h09274013;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // from Run-Test/Idle, scan n bits through the selected data register
  task automatic scan_dr(input logic [31:0] din, input int n, output logic [31:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    chk("R10 tdo_en in Shift-DR", {31'd0, tdo_en}, 32'd1);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    chk("R10 tdo_en after Shift-DR", {31'd0, tdo_en}, 32'd0);
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_ir(input logic [6:0] op, output logic [6:0] cap,
                         output logic pre_clamp, output logic pre_hiz);
    cap = '0;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 7; i++) begin
      cap[i] = tdo;
      step(i == 6, op[i]);
    end
    pre_clamp = pin_clamp;
    pre_hiz   = pin_hiz;
    step(1, 0); step(0, 0);
  endtask

  initial begin
    logic [31:0] dout, pat;
    logic [6:0] cap;
    logic pc, ph, prev_c, prev_h;
    logic [USR_W-1:0] usr_model;

    repeat (3) @(negedge tck);
    #1;
    chk("R2 tdo_en in reset", {31'd0, tdo_en}, 32'd0);
    chk("R2 pins in reset", {30'd0, pin_clamp, pin_hiz}, 32'd0);
    chk("R9 udr_q in reset", {24'd0, udr_q}, 32'd0);
    trst_n = 1'b1;
    step(1, 0); step(1, 0);
    chk("R1 TLR held by tms high", {30'd0, pin_clamp, pin_hiz}, 32'd0);
    step(0, 0);

    // R4 default instruction after reset is identification
    scan_dr(32'h0, 32, dout);
    chk("R4 idcode after reset", dout, exp_id(2'b00));

    // table walk
    prev_c = 0; prev_h = 0; usr_model = '0;
    for (int v = 0; v < NV; v++) begin
      logic [6:0] op;
      logic [1:0] kind;
      op   = VEC[v][10:4];
      kind = VEC[v][3:2];
      scan_ir(op, cap, pc, ph);
      chk("R3 capture-IR pattern", {25'd0, cap}, 32'h1);
      chk("R3 pins unchanged before Update-IR", {30'd0, pc, ph}, {30'd0, prev_c, prev_h});
      chk("R7 R8 pin outputs", {30'd0, pin_clamp, pin_hiz}, {30'd0, VEC[v][1], VEC[v][0]});
      pat = 32'hA5C30F96 ^ (32'h01010101 * v);
      scan_dr(pat, 32, dout);
      case (kind)
        2'd1: chk("R4 R5 id scan", dout, exp_id(grade_sel));
        2'd2: begin
          chk("R9 user capture then pass-through", dout, {pat[23:0], usr_model});
          usr_model = pat[31:24];
          chk("R9 user shadow after update", {24'd0, udr_q}, {24'd0, usr_model});
        end
        default: chk("R6 bypass one-bit delay", dout, {pat[30:0], 1'b0});
      endcase
      prev_c = VEC[v][1];
      prev_h = VEC[v][0];
    end

    // R9 shadow held while other registers scan
    scan_ir(7'b1111110, cap, pc, ph);
    scan_dr(32'hFFFF_FFFF, 32, dout);
    chk("R9 shadow unchanged by other scans", {24'd0, udr_q}, {24'd0, usr_model});

    // R5 speed grades
    for (int g = 1; g < 4; g++) begin
      grade_sel = g[1:0];
      scan_ir(7'b1111110, cap, pc, ph);
      scan_dr(32'h0, 32, dout);
      chk("R5 grade id value", dout, exp_id(g[1:0]));
    end
    grade_sel = 2'b00;

    // R1 five tms-high clocks from the middle of Shift-DR
    scan_ir(7'b1001001, cap, pc, ph);
    chk("R7 clamp loaded", {31'd0, pin_clamp}, 32'd1);
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 5; k++) step(1, 0);
    chk("R1 R2 clamp cleared by five tms high", {30'd0, pin_clamp, pin_hiz}, 32'd0);
    step(0, 0);
    scan_dr(32'h0, 32, dout);
    chk("R1 idcode active after tms escape", dout, exp_id(2'b00));

    // R10 tdo stable across rising edge, updates at falling edge
    scan_ir(7'b0000000, cap, pc, ph);
    step(1, 0); step(0, 0); step(0, 0);
    chk("R6 bypass captured zero", {31'd0, tdo}, 32'd0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R10 tdo held after rising edge", {31'd0, tdo}, 32'd0);
    @(negedge tck); #1;
    chk("R10 tdo updated at falling edge", {31'd0, tdo}, 32'd1);
    step(1, 0); step(1, 0); step(0, 0);

    // R2 asynchronous reset drops high-Z mid-cycle
    scan_ir(7'b1001010, cap, pc, ph);
    chk("R8 hiz loaded", {30'd0, pin_clamp, pin_hiz}, 32'd1);
    #2 trst_n = 1'b0;
    #1;
    chk("R2 async reset clears hiz", {30'd0, pin_clamp, pin_hiz}, 32'd0);
    chk("R2 async reset tdo_en", {31'd0, tdo_en}, 32'd0);
    @(negedge tck); trst_n = 1'b1; #1;
    step(0, 0);
    scan_dr(32'h0, 32, dout);
    chk("R2 idcode after async reset", dout, exp_id(2'b00));

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule